// File: doc/BRIEF.md
# Byte-Register Interrupt Level Encoder

This block gathers eight level-sensitive interrupt request lines and converts them into a 16-bit vector of processor priority level lines. Each request line has a fixed level from a sparse table. Two of the lines have level zero, and the block discards them. A request is first captured in a pending byte. The pending bits then pass through the enables in a one-byte control register. The result is an OR of one-hot level bits. The block drives this vector on its outputs and also gives the number of the highest level that is active.

The control register sits at one byte address on a simple select/write bus. Reads always return the stored byte. Writes are masked before they are stored, so one bit position can never hold a one. Bit 0 of the register is a master enable. Bits 1, 2, 3, 5 and 7 each enable the request line with the same index. Request line 4 has no enable bit of its own.

Top module: `byte_pil_encoder`

## Requirements
- R1: After reset the control register reads 0x01, every level output is low and the top-level code is 0.
- R2: A write stores the write data ANDed with 0xBF. Bit 6 of the control register therefore always reads 0, and a read returns the stored byte.
- R3: A write takes effect on the clock edge on which busSel and busWr are sampled high. A read in that same cycle returns the old value, and a read in the next cycle returns the new value.
- R4: Request lines 1, 2, 3, 4, 5 and 7 drive level outputs pilOut[1], pilOut[4], pilOut[6], pilOut[8], pilOut[10] and pilOut[14] respectively. No other pilOut bit is ever high.
- R5: Request lines 0 and 6 map to level 0. They never set a pending bit and never affect any output.
- R6: Requests are level-sensitive. When a request line goes low, its level output goes low again. If all requests are low, pilOut is zero.
- R7: When several requests are active, pilOut is the OR of their level bits.
- R8: While control bit 0 is 0, all level outputs are low. Pending requests are kept during this time, so setting bit 0 again restores their levels without any change on the request lines.
- R9: Control bits 1, 2, 3, 5 and 7 gate the request line of the same index. Request line 4 passes whenever the master enable bit is set.
- R10: pilTop gives the index of the highest high bit of pilOut, or 0 when pilOut is zero. It changes on the same clock edge as pilOut.
- R11: A request change sampled on clock edge k, or a write sampled on edge k, appears on pilOut and pilTop after edge k+1 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Selects the control register |
| busWr | input | 1 | Write when selected, read otherwise |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Control register value while selected, zero otherwise |
| irqReq | input | 8 | Level-sensitive request lines |
| pilOut | output | 16 | One line per priority level |
| pilTop | output | 4 | Highest active level, 0 if none |

## Verification
The assertions assume that busSel, busWr, busWdata and irqReq are known values after reset. They also assume that a write lasts exactly one selected cycle when the following cycle is used to read back the result. The bench drives every input on the falling clock edge and holds it for whole cycles. Each write is one cycle long and is followed by a one-cycle read. Request changes are spaced at least two cycles apart, so the one-cycle pending stage and the output register both settle before the next check.

// File: rtl/pil_enc_pkg.sv
package pil_enc_pkg;

  // Strobes handed from the bus control to the datapath
  typedef struct packed {
    logic       wrStb;
    logic       rdStb;
    logic [7:0] wrByte;
  } busStrobe_t;

  localparam int unsigned DEF_SRC_N = 8;
  localparam int unsigned DEF_LVL_N = 16;

endpackage

// File: rtl/pil_enc_ctrl.sv
module pil_enc_ctrl
  import pil_enc_pkg::*;
#(
  parameter logic [7:0] WRITE_MASK = 8'hBF
) (
  input  logic       busSel,
  input  logic       busWr,
  input  logic [7:0] busWdata,
  output busStrobe_t strb
);

  always_comb begin
    strb.wrStb  = busSel & busWr;
    strb.rdStb  = busSel;
    strb.wrByte = busWdata & WRITE_MASK;
  end

endmodule

// File: rtl/pil_enc_datapath.sv
module pil_enc_datapath
  import pil_enc_pkg::*;
#(
  parameter int unsigned SRC_N = DEF_SRC_N,
  parameter int unsigned LVL_N = DEF_LVL_N,
  parameter int unsigned LVL_W = $clog2(LVL_N),
  parameter logic [SRC_N*LVL_W-1:0] LEVEL_MAP = {4'd14, 4'd0, 4'd10, 4'd8, 4'd6, 4'd4, 4'd1, 4'd0},
  parameter logic [SRC_N-1:0] GATED_MASK = 8'hAE,
  parameter logic [SRC_N-1:0] RESET_VAL  = 8'h01,
  parameter int unsigned MASTER_BIT = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       strb,
  input  logic [SRC_N-1:0] irqReq,
  output logic [SRC_N-1:0] rdByte,
  output logic [LVL_N-1:0] pilVec,
  output logic [LVL_W-1:0] pilHigh
);

  logic [SRC_N-1:0] ctrlReg;
  logic [SRC_N-1:0] pendReg;
  logic [SRC_N-1:0] validMask;
  logic [SRC_N-1:0] eligible;
  logic [LVL_N-1:0] nextPil;
  logic [LVL_N-1:0] riseVec;
  logic [LVL_N-1:0] fallVec;
  logic [LVL_W-1:0] nextHigh;

  // Sources whose level is zero never become pending
  for (genvar s = 0; s < SRC_N; s++) begin : g_valid
    assign validMask[s] = (LEVEL_MAP[s*LVL_W +: LVL_W] != '0);
  end

  // Control byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= RESET_VAL;
    end else if (strb.wrStb) begin
      ctrlReg <= strb.wrByte[SRC_N-1:0];
    end
  end

  assign rdByte = strb.rdStb ? ctrlReg : '0;

  // Pending byte follows the request levels
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReg <= '0;
    end else begin
      pendReg <= irqReq & validMask;
    end
  end

  assign eligible = pendReg & (ctrlReg | ~GATED_MASK) & {SRC_N{ctrlReg[MASTER_BIT]}};

  // Level vector: per level, OR of the eligible sources mapped to it
  for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
    logic [SRC_N-1:0] srcSel;
    for (genvar s = 0; s < SRC_N; s++) begin : g_src
      assign srcSel[s] = (l != 0) && (LEVEL_MAP[s*LVL_W +: LVL_W] == LVL_W'(l));
    end
    assign nextPil[l] = |(srcSel & eligible);
  end

  always_comb begin
    nextHigh = '0;
    for (int l = 0; l < LVL_N; l++) begin
      if (nextPil[l]) nextHigh = LVL_W'(l);
    end
  end

  // Edge-based update against the previous output vector
  assign riseVec = nextPil & ~pilVec;
  assign fallVec = pilVec & ~nextPil;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pilVec  <= '0;
      pilHigh <= '0;
    end else begin
      pilVec  <= (pilVec | riseVec) & ~fallVec;
      pilHigh <= nextHigh;
    end
  end

endmodule

// File: rtl/byte_pil_encoder.sv
module byte_pil_encoder
  import pil_enc_pkg::*;
#(
  parameter int unsigned SRC_N = DEF_SRC_N,
  parameter int unsigned LVL_N = DEF_LVL_N,
  localparam int unsigned LVL_W = $clog2(LVL_N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [7:0]       busWdata,
  output logic [7:0]       busRdata,
  input  logic [SRC_N-1:0] irqReq,
  output logic [LVL_N-1:0] pilOut,
  output logic [LVL_W-1:0] pilTop
);

  busStrobe_t strb;
  logic [SRC_N-1:0] rdByte;

  pil_enc_ctrl #(.WRITE_MASK(8'hBF)) i_ctrl (
    .busSel   (busSel),
    .busWr    (busWr),
    .busWdata (busWdata),
    .strb     (strb)
  );

  pil_enc_datapath #(
    .SRC_N (SRC_N),
    .LVL_N (LVL_N),
    .LVL_W (LVL_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .irqReq  (irqReq),
    .rdByte  (rdByte),
    .pilVec  (pilOut),
    .pilHigh (pilTop)
  );

  assign busRdata = 8'(rdByte);

endmodule

// File: rtl/pil_enc_chk.sv
module pil_enc_chk #(
  parameter int unsigned SRC_N = 8,
  parameter int unsigned LVL_N = 16,
  parameter int unsigned LVL_W = 4,
  parameter logic [15:0] USED_LVLS = 16'h4552
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWr,
  input logic [7:0]       busWdata,
  input logic [7:0]       busRdata,
  input logic [SRC_N-1:0] irqReq,
  input logic [LVL_N-1:0] pilOut,
  input logic [LVL_W-1:0] pilTop
);

  logic [LVL_W-1:0] hiBit;
  always_comb begin
    hiBit = '0;
    for (int l = 0; l < LVL_N; l++) begin
      if (pilOut[l]) hiBit = LVL_W'(l);
    end
  end

  // R2
  bit6_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busSel |-> !busRdata[6]);

  // R3
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr) ##1 (busSel && !busWr) |-> busRdata == ($past(busWdata) & 8'hBF));

  // R4
  used_levels_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pilOut & ~USED_LVLS[LVL_N-1:0]) == '0);

  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq == '0) |=> ##1 (pilOut == '0));

  // R8
  master_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && !busWdata[0]) ##1 !(busSel && busWr) |=> (pilOut == '0));

  // R10
  top_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    pilTop == hiBit);

endmodule

bind byte_pil_encoder pil_enc_chk #(
  .SRC_N (SRC_N),
  .LVL_N (LVL_N),
  .LVL_W (LVL_W)
) i_pil_enc_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .irqReq   (irqReq),
  .pilOut   (pilOut),
  .pilTop   (pilTop)
);

// File: tb/test_byte_pil_encoder.sv
`timescale 1ns/1ps
module test_byte_pil_encoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busWdata = 8'h00;
  logic [7:0]  busRdata;
  logic [7:0]  irqReq = 8'h00;
  logic [15:0] pilOut;
  logic [3:0]  pilTop;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    bit          isRead;
    logic [7:0]  rd;
    logic [15:0] pil;
    logic [3:0]  top;
    string       tag;
  } item_t;

  item_t sb[$];
  logic [7:0] ctlModel = 8'h01;

  always #10 clk = ~clk;

  byte_pil_encoder i_byte_pil_encoder (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irqReq(irqReq),
    .pilOut(pilOut), .pilTop(pilTop)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] modelPil(input logic [7:0] irq, input logic [7:0] ctl);
    logic [15:0] v = '0;
    if (ctl[0]) begin
      for (int i = 0; i < 8; i++) begin
        if (irq[i] && (i == 4 || ctl[i])) begin
          case (i)
            1: v[1] = 1'b1;
            2: v[4] = 1'b1;
            3: v[6] = 1'b1;
            4: v[8] = 1'b1;
            5: v[10] = 1'b1;
            7: v[14] = 1'b1;
            default: ;
          endcase
        end
      end
    end
    return v;
  endfunction

  function automatic logic [3:0] modelTop(input logic [15:0] v);
    logic [3:0] t = '0;
    for (int l = 0; l < 16; l++) if (v[l]) t = 4'(l);
    return t;
  endfunction

  task automatic pushPil(input int due, input logic [15:0] p, input string tag);
    item_t it;
    it.due = due; it.isRead = 0; it.rd = '0; it.pil = p; it.top = modelTop(p); it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic pushRd(input int due, input logic [7:0] v, input string tag);
    item_t it;
    it.due = due; it.isRead = 1; it.rd = v; it.pil = '0; it.top = '0; it.tag = tag;
    sb.push_back(it);
  endtask

  // Driver: one request pattern, optionally with a write, then settle
  task automatic step(input logic [7:0] irq, input bit doWr, input logic [7:0] wd, input string tag);
    @(negedge clk);
    irqReq = irq;
    if (doWr) begin
      busSel = 1; busWr = 1; busWdata = wd;
      pushRd(cyc, ctlModel, "R3");
      ctlModel = wd & 8'hBF;
    end
    pushPil(cyc + 2, modelPil(irq, ctlModel), tag);
    @(negedge clk);
    busWr = 0; busWdata = 8'h00;
    if (doWr) pushRd(cyc, ctlModel, "R2");
    @(negedge clk);
    busSel = 0;
    @(negedge clk);
  endtask

  // Monitor: compare due items just before the next rising edge
  always @(negedge clk) begin
    #5;
    for (int k = sb.size() - 1; k >= 0; k--) begin
      if (sb[k].due == cyc) begin
        checks++;
        if (sb[k].isRead) begin
          if (busRdata !== sb[k].rd) begin
            errors++;
            $display("FAIL %s busRdata actual %02h expected %02h", sb[k].tag, busRdata, sb[k].rd);
          end
        end else if (pilOut !== sb[k].pil || pilTop !== sb[k].top) begin
          errors++;
          $display("FAIL %s pilOut/pilTop actual %04h/%0d expected %04h/%0d",
                   sb[k].tag, pilOut, pilTop, sb[k].pil, sb[k].top);
        end
        sb.delete(k);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    @(negedge clk);
    busSel = 1;
    pushRd(cyc, 8'h01, "R1");
    pushPil(cyc, 16'h0000, "R1");
    @(negedge clk);
    busSel = 0;

    // R9: reset value enables only master; source 4 passes, source 1 gated
    step(8'h02, 0, 8'h00, "R9");
    step(8'h10, 0, 8'h00, "R9");

    // R2: write all ones, bit 6 dropped; R4 source 1
    step(8'h02, 1, 8'hFF, "R4");

    // R4: each mapped source alone
    for (int i = 1; i < 8; i++) begin
      if (i != 6) step(8'(1 << i), 0, 8'h00, "R4");
    end

    // R5: sources 0 and 6 ignored
    step(8'h41, 0, 8'h00, "R5");

    // R7 and R10: combinations
    step(8'hFF, 0, 8'h00, "R7");
    step(8'h36, 0, 8'h00, "R10");

    // R8: master off keeps pending, re-enable restores
    step(8'hFF, 1, 8'h00, "R8");
    step(8'hFF, 1, 8'h01, "R8");
    step(8'hFF, 1, 8'hBF, "R8");

    // R9: only source 7 enabled plus ungated source 4
    step(8'hFF, 1, 8'h81, "R9");
    step(8'hFF, 1, 8'hFF, "R9");

    // R6: requests drop
    step(8'h00, 0, 8'h00, "R6");

    // R2: writing only bit 6 reads back zero
    step(8'h00, 1, 8'h40, "R2");
    step(8'h00, 1, 8'hBF, "R2");

    // R11: latency of two edges
    @(negedge clk);
    irqReq = 8'h80;
    pushPil(cyc + 1, 16'h0000, "R11");
    pushPil(cyc + 2, 16'h4000, "R11");
    repeat (4) @(negedge clk);
    irqReq = 8'h00;
    repeat (4) @(negedge clk);

    // R10: none active gives code 0
    pushPil(cyc, 16'h0000, "R10");
    repeat (3) @(negedge clk);

    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R11 pending items actual %0d expected 0", sb.size());
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule